// File: doc/BRIEF.md
# I2C Slave Front End for a Four-Channel Wiper Controller

This block is the bus side of a four-channel digital wiper controller. It watches an I2C bus, sampling SCL and SDA on the system clock, and drives a single pull-down enable for the open-drain SDA pad. It recognises START and STOP conditions and shifts bytes in and out most significant bit first. It also answers its own address. That address is a fixed 4-bit device-type nibble in the upper half of the first byte and four strap pins in the lower half; there is no read/write bit. Every byte the block accepts is handed to a command unit as a one-cycle strobe, together with an index that says whether the byte is the address, the instruction or a data byte.

The instruction byte decides the direction of the rest of the frame. A read opcode makes the block send bytes from the command unit back to the master, one byte per master acknowledge. Any other opcode keeps the block receiving. While the command unit reports that a non-volatile write cycle is in progress, the block leaves its address unacknowledged, so a host can poll until the cycle ends. A low write-protect input makes the block refuse the data byte of a non-volatile store: it gives no acknowledge and no strobe. The command unit is told about the STOP of every frame in which this slave was selected, which is the point where it starts any non-volatile cycle.

Top module: `pot_i2c_slave`

## Requirements
- R1: A START is SDA falling while SCL stays high, and a STOP is SDA rising while SCL stays high. After reset, and after any refused byte, the block drives nothing and accepts nothing until it sees a START.
- R2: The first byte after a START is acknowledged only when bits 7:4 equal 4'b0101 and bits 3:0 equal `strap_addr`. Any other value gets no acknowledge, and the rest of the frame is ignored.
- R3: Each accepted byte is acknowledged by holding `sda_pull` high through the ninth SCL clock. Each accepted byte also raises `rx_valid` for one cycle, with `rx_index` = 0 for the address, 1 for the instruction and 2 for the data byte and every later byte.
- R4: When bits 7:4 of the instruction are 4'b1001 or 4'b1011, the block transmits after the instruction's acknowledge. It samples `tx_data` with a one-cycle `tx_load` pulse and sends it MSB first, pulling SDA low for each 0 bit.
- R5: After each transmitted byte the block releases SDA and samples the ninth clock. An acknowledge (SDA low) loads and sends the next byte. A missing acknowledge ends transmission, with no further `tx_load` and SDA released, until the next START.
- R6: While `nv_busy` is high the address byte is not acknowledged. The first matching address after `nv_busy` falls is acknowledged.
- R7: When `wp_n` is low and the instruction's bits 7:4 are 4'b1100 (store to non-volatile register), the address and the instruction are acknowledged, but the data byte gets neither an acknowledge nor `rx_valid`.
- R8: `wp_n` has no effect on any other opcode. For example, a wiper write (bits 7:4 = 4'b1010) has its data acknowledged and delivered while `wp_n` is low.
- R9: A START in the middle of a frame (repeated START) returns the block to address reception, with the next accepted byte carrying `rx_index` 0.
- R10: `sda_pull` changes only while the synchronised SCL is low.
- R11: `frame_stop` pulses for one cycle on a STOP that ends a frame whose address this slave acknowledged, and never otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | High to pull SDA low (open-drain enable) |
| strap_addr | input | 4 | Address strap pins, compared with address bits 3:0 |
| nv_busy | input | 1 | Non-volatile write cycle running; address is refused |
| wp_n | input | 1 | Low blocks the data byte of a non-volatile store |
| rx_valid | output | 1 | One-cycle strobe for an accepted byte |
| rx_index | output | 2 | Position of the byte: 0 address, 1 instruction, 2 data |
| rx_byte | output | 8 | The accepted byte |
| tx_data | input | 8 | Byte to transmit in a read frame |
| tx_load | output | 1 | One-cycle pulse when `tx_data` is taken |
| frame_stop | output | 1 | STOP seen at the end of a frame that selected this slave |

## Verification
The assertions take for granted a well-behaved master. SDA moves only while SCL is low, except to form START and STOP. Each SCL level lasts at least four system clocks, so no two SCL edges fall into one synchroniser window, and the strap pins do not move during an address byte. The bench's bit-level master is built so it can only produce such traffic: every SDA change waits a quarter bit period after SCL falls, and START and STOP are formed only with SCL held high. Collisions with the slave's own pull-down are resolved by modelling the line as a wired AND.

// File: rtl/pot_i2c_pkg.sv
package pot_i2c_pkg;

  // Engine states
  typedef enum logic [2:0] {
    ST_IDLE,      // ignore the bus until START
    ST_RX,        // shifting in a byte
    ST_ACK_SET,   // waiting for SCL low to drive acknowledge
    ST_ACK_HOLD,  // acknowledge driven, waiting for ninth clock to end
    ST_TX,        // shifting out a byte
    ST_TX_ACK     // released, sampling master acknowledge
  } fe_state_t;

  // Byte position codes handed to the command unit
  localparam logic [1:0] IDX_ADDR  = 2'd0;
  localparam logic [1:0] IDX_INSTR = 2'd1;
  localparam logic [1:0] IDX_DATA  = 2'd2;

  // Instruction opcodes (bits 7:4 of the instruction byte) that the front end decodes
  localparam logic [3:0] OP_RD_WIPER = 4'b1001;
  localparam logic [3:0] OP_RD_STORE = 4'b1011;
  localparam logic [3:0] OP_WR_STORE = 4'b1100;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [1:0] raw;
  logic [1:0] cur;
  logic [1:0] prev;

  assign raw = {scl_i, sda_i};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], raw[g]};
      end
      assign cur[g] = chain[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 2'b11;
    else     prev <= cur;
  end

  assign scl_s     = cur[1];
  assign sda_s     = cur[0];
  assign scl_rise  =  cur[1] & ~prev[1];
  assign scl_fall  = ~cur[1] &  prev[1];
  assign start_det = prev[1] & cur[1] &  prev[0] & ~cur[0];
  assign stop_det  = prev[1] & cur[1] & ~prev[0] &  cur[0];

endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              ld,
  input  logic [BYTE_W-1:0] ld_val,
  input  logic              inc,
  input  logic              cap,
  input  logic              bit_in,
  input  logic              shl,
  output logic [BYTE_W-1:0] sh,
  output logic [CNT_W-1:0]  cnt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      cnt <= '0;
    end else if (ld) begin
      sh  <= ld_val;
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + CNT_W'(1);
      if (cap) sh <= {sh[BYTE_W-2:0], bit_in};
    end else if (shl) begin
      sh <= {sh[BYTE_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/pot_i2c_slave.sv
module pot_i2c_slave
  import pot_i2c_pkg::*;
#(
  parameter int                          BYTE_W      = 8,
  parameter int                          ADDR_W      = 4,
  parameter int                          SYNC_STAGES = 2,
  parameter logic [BYTE_W-ADDR_W-1:0]    TYPE_ID     = 4'b0101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              nv_busy,
  input  logic              wp_n,
  output logic              rx_valid,
  output logic [1:0]        rx_index,
  output logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_load,
  output logic              frame_stop
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int ID_W  = BYTE_W - ADDR_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  fe_state_t         state;
  logic [1:0]        idx;
  logic [3:0]        opcode;
  logic              sel;
  logic              ack_more;
  logic              tx_upd;
  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] full;
  logic              accept;
  logic              ev_ok, byte_end, to_tx, sh_ld, sh_clr, sh_inc, sh_shl;

  assign ev_ok    = !start_det && !stop_det;
  assign full     = {sh[BYTE_W-2:0], sda_s};
  assign byte_end = ev_ok && state == ST_RX && scl_rise && cnt == CNT_W'(BYTE_W - 1);
  assign to_tx    = (opcode == OP_RD_WIPER || opcode == OP_RD_STORE) && idx == IDX_DATA;

  assign sh_ld  = ev_ok && scl_fall &&
                  ((state == ST_ACK_HOLD && to_tx) || (state == ST_TX_ACK && ack_more));
  assign sh_clr = start_det || (ev_ok && scl_fall && state == ST_ACK_HOLD);
  assign sh_inc = ev_ok && scl_rise && (state == ST_RX || state == ST_TX);
  assign sh_shl = ev_ok && scl_fall && state == ST_TX &&
                  cnt != '0 && cnt != CNT_W'(BYTE_W);

  i2c_byte_shifter #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .clr(sh_clr), .ld(sh_ld), .ld_val(tx_data),
    .inc(sh_inc), .cap(state == ST_RX), .bit_in(sda_s), .shl(sh_shl),
    .sh(sh), .cnt(cnt)
  );

  // Accept decision for the byte completing now
  always_comb begin
    case (idx)
      IDX_ADDR:  accept = full[BYTE_W-1 -: ID_W] == TYPE_ID &&
                          full[ADDR_W-1:0] == strap_addr && !nv_busy;
      IDX_INSTR: accept = 1'b1;
      default:   accept = !(opcode == OP_WR_STORE && !wp_n);
    endcase
  end

  always_ff @(posedge clk) begin
    rx_valid   <= 1'b0;
    tx_load    <= 1'b0;
    frame_stop <= 1'b0;
    tx_upd     <= sh_ld || sh_shl;
    if (rst) begin
      state    <= ST_IDLE;
      sda_pull <= 1'b0;
      idx      <= IDX_ADDR;
      opcode   <= '0;
      sel      <= 1'b0;
      ack_more <= 1'b0;
      rx_index <= IDX_ADDR;
      rx_byte  <= '0;
      tx_upd   <= 1'b0;
    end else if (start_det) begin
      state    <= ST_RX;
      idx      <= IDX_ADDR;
      sel      <= 1'b0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      state      <= ST_IDLE;
      sda_pull   <= 1'b0;
      frame_stop <= sel;
      sel        <= 1'b0;
    end else begin
      case (state)
        ST_RX: if (byte_end) begin
          rx_byte  <= full;
          rx_index <= idx;
          if (idx != IDX_DATA) idx <= idx + 2'd1;
          if (accept) begin
            rx_valid <= 1'b1;
            state    <= ST_ACK_SET;
            if (idx == IDX_ADDR)  sel    <= 1'b1;
            if (idx == IDX_INSTR) opcode <= full[BYTE_W-1 -: 4];
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_ACK_SET: if (scl_fall) begin
          sda_pull <= 1'b1;
          state    <= ST_ACK_HOLD;
        end
        ST_ACK_HOLD: if (scl_fall) begin
          sda_pull <= 1'b0;
          if (to_tx) begin
            tx_load <= 1'b1;
            state   <= ST_TX;
          end else begin
            state <= ST_RX;
          end
        end
        ST_TX: begin
          if (tx_upd) sda_pull <= ~sh[BYTE_W-1];
          if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
            sda_pull <= 1'b0;
            state    <= ST_TX_ACK;
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) ack_more <= !sda_s;
          if (scl_fall) begin
            if (ack_more) begin
              tx_load <= 1'b1;
              state   <= ST_TX;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pot_i2c_slave_chk.sv
module pot_i2c_slave_chk
  import pot_i2c_pkg::*;
#(
  parameter int                       BYTE_W  = 8,
  parameter int                       ADDR_W  = 4,
  parameter logic [BYTE_W-ADDR_W-1:0] TYPE_ID = 4'b0101
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_s,
  input logic              stop_det,
  input logic              sda_pull,
  input logic              rx_valid,
  input logic [1:0]        rx_index,
  input logic [BYTE_W-1:0] rx_byte,
  input logic [ADDR_W-1:0] strap_addr,
  input logic              nv_busy,
  input logic              wp_n,
  input logic [3:0]        opcode,
  input logic              frame_stop
);

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (sda_pull != $past(sda_pull)) |-> !$past(scl_s)); // R10

  AST_ADDR_MATCH: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_index == IDX_ADDR) |-> rx_byte == {TYPE_ID, $past(strap_addr)}); // R2

  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_index == IDX_ADDR) |-> !$past(nv_busy)); // R6

  AST_WP_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_index == IDX_DATA && opcode == OP_WR_STORE) |-> $past(wp_n)); // R7

  AST_STOP_SOURCE: assert property (@(posedge clk) disable iff (rst)
    frame_stop |-> $past(stop_det)); // R11

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R3

  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> rx_index != 2'd3); // R3

endmodule

bind pot_i2c_slave pot_i2c_slave_chk #(
  .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .TYPE_ID(TYPE_ID)
) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .stop_det(stop_det), .sda_pull(sda_pull),
  .rx_valid(rx_valid), .rx_index(rx_index), .rx_byte(rx_byte),
  .strap_addr(strap_addr), .nv_busy(nv_busy), .wp_n(wp_n), .opcode(opcode),
  .frame_stop(frame_stop)
);

// File: tb/test_pot_i2c_slave.sv
`timescale 1ns/1ps
module test_pot_i2c_slave;

  localparam int Q = 4;  // quarter SCL period in system clocks

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_pull;
  logic [3:0] strap = 4'h0;
  logic       nv_busy = 1'b0;
  logic       wp_n = 1'b1;
  logic       rx_valid;
  logic [1:0] rx_index;
  logic [7:0] rx_byte;
  logic [7:0] tx_data = 8'h00;
  logic [7:0] tx_next = 8'h00;
  logic       tx_load;
  logic       frame_stop;
  wire        sda_line = sda_m & ~sda_pull;

  always #4 clk = ~clk;

  pot_i2c_slave i_pot_i2c_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_pull(sda_pull),
    .strap_addr(strap), .nv_busy(nv_busy), .wp_n(wp_n),
    .rx_valid(rx_valid), .rx_index(rx_index), .rx_byte(rx_byte),
    .tx_data(tx_data), .tx_load(tx_load), .frame_stop(frame_stop)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // Observation of the command-side outputs
  logic [7:0] lg_byte [16];
  logic [1:0] lg_idx  [16];
  int  lg_n = 0, fs_n = 0, tl_n = 0, viol = 0;
  logic prev_pull = 1'b0;

  always @(negedge clk) begin
    if (rx_valid) begin
      if (lg_n < 16) begin
        lg_byte[lg_n] = rx_byte;
        lg_idx[lg_n]  = rx_index;
      end
      lg_n++;
    end
    if (frame_stop) fs_n++;
    if (tx_load) begin
      tl_n++;
      tx_data <= tx_next;
    end
    if (!rst && sda_pull !== prev_pull && scl_m) viol++;
    prev_pull = sda_pull;
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    scl_m = 1'b0; sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    acked = (sda_line == 1'b0);
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(2*Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
      scl_m = 1'b0;
    end
    sda_m = give_ack ? 1'b0 : 1'b1; tick(2*Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    bit ak;
    logic [7:0] rb;
    int fs0;
    tick(5); rst = 1'b0; tick(5);

    // Reset state
    chk("R3", sda_pull, 0, "sda_pull after reset");
    chk("R3", rx_valid, 0, "rx_valid after reset");
    chk("R11", frame_stop, 0, "frame_stop after reset");

    // R1: matching address clocked without a START is ignored
    strap = 4'h5;
    send_byte(8'h55, ak);
    chk("R1", ak, 0, "ack without START");
    chk("R1", lg_n, 0, "strobes without START");
    bus_stop;
    chk("R1", fs_n, 0, "frame_stop without selection");

    // R2/R11: sweep strap pins against address low nibble
    for (int s = 0; s < 16; s++) begin
      strap = 4'(s);
      for (int a = 0; a < 16; a++) begin
        fs0 = fs_n;
        bus_start;
        send_byte({4'b0101, 4'(a)}, ak);
        bus_stop;
        chk("R2", ak, (a == s) ? 1 : 0, "ack for address low nibble");
        chk("R11", fs_n - fs0, (a == s) ? 1 : 0, "frame_stop count");
      end
    end
    // R2: sweep the type nibble with matching strap
    strap = 4'h6;
    for (int t = 0; t < 16; t++) begin
      bus_start;
      send_byte({4'(t), 4'h6}, ak);
      bus_stop;
      chk("R2", ak, (t == 5) ? 1 : 0, "ack for type nibble");
    end

    // R3/R8: wiper write with write protect active is fully accepted
    strap = 4'h3; wp_n = 1'b0; lg_n = 0;
    bus_start;
    send_byte(8'h53, ak); chk("R3", ak, 1, "address ack");
    send_byte(8'hA1, ak); chk("R3", ak, 1, "instruction ack");
    send_byte(8'h3C, ak); chk("R8", ak, 1, "wiper data ack under protect");
    send_byte(8'h11, ak); chk("R3", ak, 1, "extra data ack");
    bus_stop;
    chk("R3", lg_n, 4, "strobe count");
    chk("R3", lg_idx[0], 0, "index of address");
    chk("R3", lg_byte[0], 8'h53, "address byte");
    chk("R3", lg_idx[1], 1, "index of instruction");
    chk("R3", lg_byte[1], 8'hA1, "instruction byte");
    chk("R8", lg_idx[2], 2, "index of data");
    chk("R8", lg_byte[2], 8'h3C, "data byte");
    chk("R3", lg_idx[3], 2, "index saturates");

    // R7: store with write protect active is refused on data
    lg_n = 0;
    bus_start;
    send_byte(8'h53, ak); chk("R7", ak, 1, "address ack under protect");
    send_byte(8'hC6, ak); chk("R7", ak, 1, "instruction ack under protect");
    send_byte(8'h77, ak); chk("R7", ak, 0, "store data refused");
    send_byte(8'h12, ak); chk("R7", ak, 0, "bytes after refusal ignored");
    bus_stop;
    chk("R7", lg_n, 2, "no strobe for refused data");

    // R7: same store with protect released
    wp_n = 1'b1; lg_n = 0;
    bus_start;
    send_byte(8'h53, ak);
    send_byte(8'hC6, ak);
    send_byte(8'h77, ak); chk("R7", ak, 1, "store data ack when unprotected");
    bus_stop;
    chk("R7", lg_n, 3, "strobes when unprotected");
    chk("R7", lg_byte[2], 8'h77, "store data byte");

    // R6: busy refuses address, polling succeeds afterwards
    nv_busy = 1'b1; lg_n = 0; fs0 = fs_n;
    bus_start;
    send_byte(8'h53, ak); chk("R6", ak, 0, "address refused while busy");
    bus_stop;
    chk("R6", lg_n, 0, "no strobe while busy");
    chk("R11", fs_n - fs0, 0, "no frame_stop while busy");
    nv_busy = 1'b0;
    bus_start;
    send_byte(8'h53, ak); chk("R6", ak, 1, "address ack after busy");
    bus_stop;

    // R4/R5: read with master ack then nack
    tx_data = 8'hA5; tx_next = 8'h5A; tl_n = 0;
    bus_start;
    send_byte(8'h53, ak);
    send_byte(8'h92, ak); chk("R4", ak, 1, "read instruction ack");
    recv_byte(1'b1, rb); chk("R4", rb, 8'hA5, "first read byte");
    recv_byte(1'b0, rb); chk("R5", rb, 8'h5A, "second read byte after ack");
    recv_byte(1'b0, rb); chk("R5", rb, 8'hFF, "line released after nack");
    bus_stop;
    chk("R5", tl_n, 2, "tx_load count");

    // R4: the other read opcode
    tx_data = 8'hC3; tx_next = 8'hC3; tl_n = 0;
    bus_start;
    send_byte(8'h53, ak);
    send_byte(8'hB0, ak);
    recv_byte(1'b0, rb); chk("R4", rb, 8'hC3, "read of stored register");
    bus_stop;
    chk("R4", tl_n, 1, "single tx_load");

    // R9: repeated START mid-frame
    lg_n = 0;
    bus_start;
    send_byte(8'h53, ak);
    send_byte(8'hA0, ak);
    bus_start;
    send_byte(8'h53, ak); chk("R9", ak, 1, "address ack after repeated START");
    send_byte(8'hA2, ak);
    send_byte(8'h44, ak); chk("R9", ak, 1, "data ack after repeated START");
    bus_stop;
    chk("R9", lg_n, 5, "strobe count");
    chk("R9", lg_idx[2], 0, "index reset by repeated START");
    chk("R9", lg_idx[4], 2, "data index after repeated START");
    chk("R9", lg_byte[4], 8'h44, "data after repeated START");

    chk("R10", viol, 0, "sda_pull changes while SCL high");

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule